// File: doc/BRIEF.md
# Per-core local interrupt router

This block sits between a four-core processor cluster and the interrupt sources that belong to each core: four architectural timer lines per core, four mailbox-nonzero lines per core, one performance-monitor line per core, and a single shared peripheral interrupt line coming from a downstream controller. For every core it drives one normal interrupt (IRQ) and one fast interrupt (FIQ) output. Software steers each source to IRQ or FIQ through per-core control words, routes the shared peripheral line to exactly one core for each of the two interrupt kinds, and turns performance-monitor interrupts on and off per core through a pair of set and clear registers.

Each core can read back two pending words, one for IRQ and one for FIQ. Both show live levels with a fixed bit layout, and the core's output of each kind is the OR of its pending word. All state is reached through a simple 32-bit register port. A request with write strobe low returns data on `bus_rdata_o` one cycle later. A request with the strobe high updates the register at the next clock edge.

Top module: `local_irq_router`

## Requirements
- R1: After reset every timer and mailbox control word, the performance-monitor enables and the routing word are 0. Every IRQ and FIQ output is low, and the shared peripheral line is routed to core 0 for both kinds.
- R2: Timer control word of core c is at 0x40+4c, with IRQ enables in bits [3:0] and FIQ enables in bits [7:4]. A timer line with only its IRQ enable set appears in IRQ pending bit s, where s is 0..3 for the secure physical, non-secure physical, hypervisor and virtual timers.
- R3: When both enables of a timer or mailbox source are set, the source shows only in the FIQ pending word and never in the IRQ pending word.
- R4: Mailbox control word of core c is at 0x50+4c with the same IRQ [3:0] and FIQ [7:4] layout. Mailbox m of core c appears in pending bit 4+m.
- R5: Routing word at 0x0C: bits [1:0] select the core that receives the peripheral line as IRQ, and bits [3:2] select the core that receives it as FIQ. It shows in pending bit 8 of the selected core only.
- R6: Writing to 0x10 sets the performance-monitor enable of every core whose bit in [3:0] is 1. Enables of cores whose bit is 0 are unchanged.
- R7: Writing to 0x14 clears the performance-monitor enable of every core whose bit in [3:0] is 1. Enables of cores whose bit is 0 are unchanged. Reads of 0x10 and 0x14 both return the enables in [3:0].
- R8: An enabled performance-monitor line appears in IRQ pending bit 9 and raises the core's IRQ. It never appears in the FIQ pending word.
- R9: irq_o[c] is high exactly when the IRQ pending word of core c is nonzero, and fiq_o[c] is high exactly when its FIQ pending word is nonzero.
- R10: IRQ pending words at 0x60+4c and FIQ pending words at 0x70+4c are read-only and return the current levels. Writes to them have no effect.
- R11: Reads of any other offset, including offsets that are not word aligned, return 0. Writes to them change no state.
- R12: Read data appears on bus_rdata_o in the cycle after the read request and is 0 in every other cycle. Control words read back in bits [7:0] and the routing word in [3:0], with all upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (8) | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after a read request |
| timer_i | input | NUM_CORES*4 | Timer lines, core c in bits [4c+3:4c] |
| mbox_i | input | NUM_CORES*4 | Mailbox-nonzero lines, core c in bits [4c+3:4c] |
| periph_i | input | 1 | Shared peripheral interrupt |
| pmu_i | input | NUM_CORES | Performance-monitor line per core |
| irq_o | output | NUM_CORES | IRQ per core |
| fiq_o | output | NUM_CORES | FIQ per core |

## Verification
Timer and mailbox lines are driven under three enable settings: IRQ only, FIQ only, and both set. The both-set case is what separates a correct FIQ override from a design that reports the source twice or drops it. The peripheral line is toggled with IRQ and FIQ routed to different cores and then to the same core, which shows whether routing selects a single core per kind. Performance-monitor writes use masks with mixed ones and zeros to show that zero bits leave the enables alone. Pending reads are taken with lines active and idle, and writes to pending and unmapped offsets are followed by read-back and output comparison to confirm they changed nothing.

// File: rtl/lir_pkg.sv
package lir_pkg;
  localparam int SRC_PER_CORE = 4;
  localparam int PEND_W       = 10;
  localparam int BIT_MBOX     = 4;
  localparam int BIT_PERIPH   = 8;
  localparam int BIT_PMU      = 9;
  localparam int ROUTE_W      = 2;

  localparam logic [7:0] OFS_ROUTE   = 8'h0C;
  localparam logic [7:0] OFS_PMU_SET = 8'h10;
  localparam logic [7:0] OFS_PMU_CLR = 8'h14;
  localparam logic [7:0] OFS_TCTL    = 8'h40;
  localparam logic [7:0] OFS_MCTL    = 8'h50;
  localparam logic [7:0] OFS_IRQP    = 8'h60;
  localparam logic [7:0] OFS_FIQP    = 8'h70;

  typedef struct packed {
    logic [SRC_PER_CORE-1:0] fiq_en;
    logic [SRC_PER_CORE-1:0] irq_en;
  } steer_ctl_t;

  function automatic logic [7:0] core_word(logic [7:0] base, int c);
    return base + 8'(4 * c);
  endfunction
endpackage

// File: rtl/lir_regs.sv
module lir_regs
  import lir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output steer_ctl_t [NUM_CORES-1:0]    tctl_o,
  output steer_ctl_t [NUM_CORES-1:0]    mctl_o,
  output logic [ROUTE_W-1:0]            route_irq_o,
  output logic [ROUTE_W-1:0]            route_fiq_o,
  output logic [NUM_CORES-1:0]          pmu_en_o
);
  logic       in_range;
  logic [7:0] a8;
  logic       wr_ok;

  assign in_range = (addr_i >> 8) == '0;
  assign a8       = addr_i[7:0];
  assign wr_ok    = wr_en_i && in_range;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_ctl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tctl_o[c] <= '0;
        mctl_o[c] <= '0;
      end else if (wr_ok) begin
        if (a8 == core_word(OFS_TCTL, c)) tctl_o[c] <= steer_ctl_t'(wdata_i[7:0]);
        if (a8 == core_word(OFS_MCTL, c)) mctl_o[c] <= steer_ctl_t'(wdata_i[7:0]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_irq_o <= '0;
      route_fiq_o <= '0;
    end else if (wr_ok && a8 == OFS_ROUTE) begin
      route_irq_o <= wdata_i[ROUTE_W-1:0];
      route_fiq_o <= wdata_i[2*ROUTE_W-1:ROUTE_W];
    end
  end

  // set and clear live at distinct offsets, so at most one mask is nonzero
  logic [NUM_CORES-1:0] set_mask, clr_mask;
  assign set_mask = (wr_ok && a8 == OFS_PMU_SET) ? wdata_i[NUM_CORES-1:0] : '0;
  assign clr_mask = (wr_ok && a8 == OFS_PMU_CLR) ? wdata_i[NUM_CORES-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pmu_en_o <= '0;
    else         pmu_en_o <= (pmu_en_o | set_mask) & ~clr_mask;
  end
endmodule

// File: rtl/lir_steer.sv
module lir_steer
  import lir_pkg::*;
(
  input  steer_ctl_t                tctl_i,
  input  steer_ctl_t                mctl_i,
  input  logic [SRC_PER_CORE-1:0]   timer_i,
  input  logic [SRC_PER_CORE-1:0]   mbox_i,
  input  logic                      periph_irq_i,
  input  logic                      periph_fiq_i,
  input  logic                      pmu_i,
  output logic [PEND_W-1:0]         irq_pend_o,
  output logic [PEND_W-1:0]         fiq_pend_o
);
  always_comb begin
    irq_pend_o = '0;
    fiq_pend_o = '0;
    for (int s = 0; s < SRC_PER_CORE; s++) begin
      // FIQ enable overrides IRQ enable
      irq_pend_o[s]          = timer_i[s] & tctl_i.irq_en[s] & ~tctl_i.fiq_en[s];
      fiq_pend_o[s]          = timer_i[s] & tctl_i.fiq_en[s];
      irq_pend_o[BIT_MBOX+s] = mbox_i[s] & mctl_i.irq_en[s] & ~mctl_i.fiq_en[s];
      fiq_pend_o[BIT_MBOX+s] = mbox_i[s] & mctl_i.fiq_en[s];
    end
    irq_pend_o[BIT_PERIPH] = periph_irq_i;
    fiq_pend_o[BIT_PERIPH] = periph_fiq_i;
    irq_pend_o[BIT_PMU]    = pmu_i;
  end
endmodule

// File: rtl/lir_rd_port.sv
module lir_rd_port
  import lir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                rd_en_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  steer_ctl_t [NUM_CORES-1:0]          tctl_i,
  input  steer_ctl_t [NUM_CORES-1:0]          mctl_i,
  input  logic [ROUTE_W-1:0]                  route_irq_i,
  input  logic [ROUTE_W-1:0]                  route_fiq_i,
  input  logic [NUM_CORES-1:0]                pmu_en_i,
  input  logic [NUM_CORES-1:0][PEND_W-1:0]    irq_pend_i,
  input  logic [NUM_CORES-1:0][PEND_W-1:0]    fiq_pend_i,
  output logic [DATA_W-1:0]                   rdata_o
);
  logic [7:0]        a8;
  logic              in_range;
  logic [DATA_W-1:0] rd_val;

  assign a8       = addr_i[7:0];
  assign in_range = (addr_i >> 8) == '0;

  always_comb begin
    rd_val = '0;
    if (in_range) begin
      if (a8 == OFS_ROUTE) rd_val[2*ROUTE_W-1:0] = {route_fiq_i, route_irq_i};
      if (a8 == OFS_PMU_SET || a8 == OFS_PMU_CLR) rd_val[NUM_CORES-1:0] = pmu_en_i;
      for (int c = 0; c < NUM_CORES; c++) begin
        if (a8 == core_word(OFS_TCTL, c)) rd_val[7:0]        = tctl_i[c];
        if (a8 == core_word(OFS_MCTL, c)) rd_val[7:0]        = mctl_i[c];
        if (a8 == core_word(OFS_IRQP, c)) rd_val[PEND_W-1:0] = irq_pend_i[c];
        if (a8 == core_word(OFS_FIQP, c)) rd_val[PEND_W-1:0] = fiq_pend_i[c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_en_i ? rd_val : '0;
  end
endmodule

// File: rtl/local_irq_router.sv
module local_irq_router
  import lir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            bus_req_i,
  input  logic                            bus_we_i,
  input  logic [ADDR_W-1:0]               bus_addr_i,
  input  logic [DATA_W-1:0]               bus_wdata_i,
  output logic [DATA_W-1:0]               bus_rdata_o,
  input  logic [NUM_CORES*SRC_PER_CORE-1:0] timer_i,
  input  logic [NUM_CORES*SRC_PER_CORE-1:0] mbox_i,
  input  logic                            periph_i,
  input  logic [NUM_CORES-1:0]            pmu_i,
  output logic [NUM_CORES-1:0]            irq_o,
  output logic [NUM_CORES-1:0]            fiq_o
);
  steer_ctl_t [NUM_CORES-1:0]        tctl, mctl;
  logic [ROUTE_W-1:0]                route_irq, route_fiq;
  logic [NUM_CORES-1:0]              pmu_en;
  logic [NUM_CORES-1:0][PEND_W-1:0]  irq_pend, fiq_pend;

  lir_regs #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (bus_req_i && bus_we_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .tctl_o      (tctl),
    .mctl_o      (mctl),
    .route_irq_o (route_irq),
    .route_fiq_o (route_fiq),
    .pmu_en_o    (pmu_en)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    lir_steer u_steer (
      .tctl_i       (tctl[c]),
      .mctl_i       (mctl[c]),
      .timer_i      (timer_i[c*SRC_PER_CORE +: SRC_PER_CORE]),
      .mbox_i       (mbox_i[c*SRC_PER_CORE +: SRC_PER_CORE]),
      .periph_irq_i (periph_i && route_irq == ROUTE_W'(c)),
      .periph_fiq_i (periph_i && route_fiq == ROUTE_W'(c)),
      .pmu_i        (pmu_i[c] && pmu_en[c]),
      .irq_pend_o   (irq_pend[c]),
      .fiq_pend_o   (fiq_pend[c])
    );
    assign irq_o[c] = |irq_pend[c];
    assign fiq_o[c] = |fiq_pend[c];
  end

  lir_rd_port #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (bus_req_i && !bus_we_i),
    .addr_i      (bus_addr_i),
    .tctl_i      (tctl),
    .mctl_i      (mctl),
    .route_irq_i (route_irq),
    .route_fiq_i (route_fiq),
    .pmu_en_i    (pmu_en),
    .irq_pend_i  (irq_pend),
    .fiq_pend_i  (fiq_pend),
    .rdata_o     (bus_rdata_o)
  );
endmodule

// File: rtl/lir_checker.sv
module lir_checker
  import lir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               bus_req_i,
  input logic                               bus_we_i,
  input logic [ADDR_W-1:0]                  bus_addr_i,
  input logic [DATA_W-1:0]                  bus_wdata_i,
  input logic [DATA_W-1:0]                  bus_rdata_o,
  input logic [NUM_CORES*SRC_PER_CORE-1:0]  timer_i,
  input logic [NUM_CORES*SRC_PER_CORE-1:0]  mbox_i,
  input logic                               periph_i,
  input logic [NUM_CORES-1:0]               pmu_i,
  input logic [NUM_CORES-1:0]               irq_o,
  input logic [NUM_CORES-1:0]               fiq_o,
  input logic [NUM_CORES-1:0]               pmu_en,
  input logic [NUM_CORES-1:0][PEND_W-1:0]   irq_pend,
  input logic [NUM_CORES-1:0][PEND_W-1:0]   fiq_pend
);
  function automatic logic mapped(logic [ADDR_W-1:0] a);
    if ((a >> 8) != '0 || a[1:0] != 2'b00) return 1'b0;
    if (a[7:0] == 8'h0C || a[7:0] == 8'h10 || a[7:0] == 8'h14) return 1'b1;
    if (a[7:6] == 2'b01 && int'(a[3:2]) < NUM_CORES) return 1'b1;
    return 1'b0;
  endfunction

  logic [NUM_CORES-1:0] periph_irq_col, periph_fiq_col;
  logic                 pmu_set_wr, pmu_clr_wr, rd_req;
  logic [NUM_CORES-1:0] wmask;

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      periph_irq_col[c] = irq_pend[c][BIT_PERIPH];
      periph_fiq_col[c] = fiq_pend[c][BIT_PERIPH];
    end
  end

  assign pmu_set_wr = bus_req_i && bus_we_i && bus_addr_i == ADDR_W'(8'h10);
  assign pmu_clr_wr = bus_req_i && bus_we_i && bus_addr_i == ADDR_W'(8'h14);
  assign rd_req     = bus_req_i && !bus_we_i;
  assign wmask      = bus_wdata_i[NUM_CORES-1:0];

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
    // R3
    a_r3_fiq_excludes_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_pend[c][7:0] & fiq_pend[c][7:0]) == 8'h00);
    // R8
    a_r8_pmu_raises_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pmu_i[c] && pmu_en[c]) |-> irq_o[c]);
    // R9
    a_r9_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (timer_i[c*4 +: 4] == 4'h0 && mbox_i[c*4 +: 4] == 4'h0 && !periph_i && !pmu_i[c])
        |-> (!irq_o[c] && !fiq_o[c]));
  end

  a_r5_periph_irq_one_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(periph_irq_col) == int'(periph_i));
  a_r5_periph_fiq_one_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(periph_fiq_col) == int'(periph_i));
  a_r6_pmu_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pmu_set_wr |=> ((pmu_en & $past(wmask)) == $past(wmask)) &&
                   ((pmu_en & ~$past(wmask)) == ($past(pmu_en) & ~$past(wmask))));
  a_r7_pmu_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pmu_clr_wr |=> ((pmu_en & $past(wmask)) == '0) &&
                   ((pmu_en & ~$past(wmask)) == ($past(pmu_en) & ~$past(wmask))));
  a_r11_unmapped_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !mapped(bus_addr_i)) |=> bus_rdata_o == '0);
  a_r12_idle_rdata_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> bus_rdata_o == '0);
endmodule

bind local_irq_router lir_checker #(
  .NUM_CORES (NUM_CORES),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_lir_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .timer_i     (timer_i),
  .mbox_i      (mbox_i),
  .periph_i    (periph_i),
  .pmu_i       (pmu_i),
  .irq_o       (irq_o),
  .fiq_o       (fiq_o),
  .pmu_en      (pmu_en),
  .irq_pend    (irq_pend),
  .fiq_pend    (fiq_pend)
);

// File: tb/local_irq_router_tb_top.sv
`timescale 1ns/1ps
module local_irq_router_tb_top;
  localparam int CLK_P = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] timer = '0, mbox = '0;
  logic        periph = 1'b0;
  logic [3:0]  pmu = '0;
  logic [3:0]  irq, fiq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  int unsigned m_tctl[4], m_mctl[4];
  int unsigned m_route = 0, m_pmu = 0;

  always #(CLK_P/2) clk = ~clk;

  local_irq_router dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .timer_i(timer), .mbox_i(mbox),
    .periph_i(periph), .pmu_i(pmu), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int unsigned pend_word(int c, bit fq);
    int unsigned w = 0;
    for (int s = 0; s < 4; s++) begin
      bit ti = m_tctl[c][s],   tf = m_tctl[c][s+4];
      bit mi = m_mctl[c][s],   mf = m_mctl[c][s+4];
      if (timer[c*4+s] && (fq ? tf : (ti && !tf))) w |= 1 << s;
      if (mbox[c*4+s]  && (fq ? mf : (mi && !mf))) w |= 1 << (s + 4);
    end
    if (periph && ((fq ? (m_route >> 2) & 3 : m_route & 3) == c)) w |= 1 << 8;
    if (!fq && pmu[c] && m_pmu[c]) w |= 1 << 9;
    return w;
  endfunction

  function automatic int unsigned exp_read(int unsigned a);
    if (a[1:0] != 0) return 0;
    if (a == 'h0C) return m_route;
    if (a == 'h10 || a == 'h14) return m_pmu;
    if (a >= 'h40 && a < 'h50) return m_tctl[(a - 'h40) / 4];
    if (a >= 'h50 && a < 'h60) return m_mctl[(a - 'h50) / 4];
    if (a >= 'h60 && a < 'h70) return pend_word((a - 'h60) / 4, 1'b0);
    if (a >= 'h70 && a < 'h80) return pend_word((a - 'h70) / 4, 1'b1);
    return 0;
  endfunction

  // R9: outputs compared with the model on every clock, mid low phase
  always @(negedge clk) begin
    #2;
    if (rst_n && !done)
      for (int c = 0; c < 4; c++) begin
        check($sformatf("R9 irq core%0d", c), 32'(irq[c]), 32'(pend_word(c, 1'b0) != 0));
        check($sformatf("R9 fiq core%0d", c), 32'(fiq[c]), 32'(pend_word(c, 1'b1) != 0));
      end
  end

  task automatic wr(int unsigned a, int unsigned d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 8'(a); wdata = d;
    @(posedge clk);
    if (a == 'h0C) m_route = d & 'hF;
    else if (a == 'h10) m_pmu |= d & 'hF;
    else if (a == 'h14) m_pmu &= ~d & 'hF;
    else if (a >= 'h40 && a < 'h50 && a[1:0] == 0) m_tctl[(a - 'h40) / 4] = d & 'hFF;
    else if (a >= 'h50 && a < 'h60 && a[1:0] == 0) m_mctl[(a - 'h50) / 4] = d & 'hFF;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(string tag, int unsigned a);
    int unsigned e;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 8'(a);
    e = exp_read(a);
    @(negedge clk);
    req = 1'b0;
    #2;
    check(tag, rdata, e);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin m_tctl[c] = 0; m_mctl[c] = 0; end
    repeat (3) @(negedge clk);
    check("R1 irq during reset", 32'(irq), 32'h0);
    check("R1 fiq during reset", 32'(fiq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R1 tctl0 reset", 'h40);
    rd("R1 mctl3 reset", 'h5C);
    rd("R1 route reset", 'h0C);
    rd("R1 pmu reset", 'h10);
    rd("R12 idle rdata", 'h0C);
    @(negedge clk); #2;
    check("R12 rdata zero without read", rdata, 32'h0);
    // R1: peripheral line goes to core 0 after reset
    @(negedge clk); periph = 1'b1;
    rd("R1 core0 irq pend periph", 'h60);
    rd("R1 core0 fiq pend periph", 'h70);
    rd("R5 core1 no periph", 'h64);
    @(negedge clk); periph = 1'b0;

    // R2: timers, IRQ only
    wr('h40, 'h0F);
    wr('h48, 'hFFFF_FF05);
    rd("R12 tctl2 readback", 'h48);
    @(negedge clk); timer = 16'h0F5F;
    rd("R2 core0 irq pend", 'h60);
    rd("R2 core2 irq pend", 'h68);
    rd("R2 core1 no enable", 'h64);
    // R3: FIQ override
    wr('h40, 'h3C);
    rd("R3 core0 irq pend", 'h60);
    rd("R3 core0 fiq pend", 'h70);
    wr('h44, 'hF0);
    rd("R3 core1 fiq pend", 'h74);
    @(negedge clk); timer = 16'h0;

    // R4: mailboxes
    wr('h5C, 'h81);
    wr('h50, 'h22);
    @(negedge clk); mbox = 16'h9003;
    rd("R4 core3 irq pend", 'h6C);
    rd("R4 core3 fiq pend", 'h7C);
    rd("R4 core0 irq pend", 'h60);
    rd("R4 core0 fiq pend", 'h70);
    @(negedge clk); mbox = 16'hFFFF; timer = 16'hFFFF;
    repeat (2) @(negedge clk);
    @(negedge clk); mbox = 16'h0; timer = 16'h0;

    // R5: routing
    wr('h0C, 'hFFF6);
    rd("R5 route readback", 'h0C);
    @(negedge clk); periph = 1'b1;
    rd("R5 core2 irq", 'h68);
    rd("R5 core1 fiq", 'h74);
    rd("R5 core0 irq none", 'h60);
    wr('h0C, 'hF);
    rd("R5 core3 both irq", 'h6C);
    rd("R5 core3 both fiq", 'h7C);
    @(negedge clk); periph = 1'b0;

    // R6/R7/R8: performance monitor
    @(negedge clk); pmu = 4'hF;
    wr('h10, 'h5);
    rd("R6 pmu set", 'h10);
    wr('h10, 'h2);
    rd("R6 zeros keep", 'h14);
    rd("R8 core1 irq pend", 'h64);
    rd("R8 core1 fiq pend none", 'h74);
    wr('h14, 'h4);
    rd("R7 pmu clr", 'h10);
    wr('h14, 'h0);
    rd("R7 zero clr keeps", 'h14);
    @(negedge clk); pmu = 4'h0;

    // R10: pending read-only and live
    @(negedge clk); timer = 16'h0001;
    wr('h60, 'h3FF);
    wr('h70, 'h3FF);
    rd("R10 irq pend live", 'h60);
    rd("R10 fiq pend live", 'h70);
    @(negedge clk); timer = 16'h0;
    rd("R10 pend follows drop", 'h70);

    // R11: unmapped offsets
    wr('h20, 'hFFFF_FFFF);
    wr('h41, 'hFF);
    wr('h80, 'hFF);
    rd("R11 unmapped 0x20", 'h20);
    rd("R11 unaligned 0x41", 'h41);
    rd("R11 unmapped 0x80", 'h80);
    rd("R11 unmapped 0x18", 'h18);
    rd("R11 tctl0 untouched", 'h40);
    rd("R11 route untouched", 'h0C);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog (all) act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule